// File: doc/BRIEF.md
# RAM Digit Pointer with Skip

This block holds the 6-bit data-memory pointer of a small 4-bit controller. The pointer has two fields. The upper 2 bits pick one of four memory registers. The lower 4 bits pick a digit. From these fields the block forms the 5-bit physical address of a 32 x 4 RAM.

An instruction decoder drives one-cycle command strobes:

- load both fields from immediate operands;
- copy the accumulator into the digit field;
- step the digit field up or down, flipping the register field with a 2-bit operand;
- step the digit field up as part of a store-immediate, with no flip and no skip.

A separate override input forces the address to register 3, digit 15 for that cycle and leaves the pointer as it is. The current field values stay visible, so the datapath can read the digit back into the accumulator.

Only the low three digit bits reach the RAM, so digit values d and d+8 name the same physical cell. Each up or down step returns a skip flag. The flag is set only when the digit field wraps around its full 4-bit range. Moving between 7 and 8 never raises it.

Top module: `ram_digit_ptr`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `ptr_reg`, `ptr_dig` and `skip` are all 0.
- R2: After a clock edge with `cmd_load` high, `ptr_reg` equals `load_reg`, `ptr_dig` equals `load_dig` and `skip` is 0.
- R3: After an edge where `cmd_copy` wins arbitration, `ptr_dig` equals `acc_in`, `ptr_reg` is unchanged and `skip` is 0.
- R4: After an edge where `cmd_inc` wins, `ptr_dig` becomes (old + 1) mod 16 and `ptr_reg` becomes old XOR `step_r`. `skip` is 1 for that one cycle exactly when the old digit was 15.
- R5: After an edge where `cmd_dec` wins, `ptr_dig` becomes (old + 15) mod 16 and `ptr_reg` becomes old XOR `step_r`. `skip` is 1 for that one cycle exactly when the old digit was 0.
- R6: After an edge where `cmd_stinc` wins, `ptr_dig` becomes (old + 1) mod 16, `ptr_reg` is unchanged (`step_r` is ignored) and `skip` is 0, including on the 15-to-0 wrap.
- R7: With `cmd_direct` low, `phys_addr` equals `ptr_reg`*8 + (`ptr_dig` mod 8). Digits d and d+8 therefore give the same address.
- R8: With `cmd_direct` high, `phys_addr` is 31 (register 3, digit 15) in the same cycle. The override alone does not change `ptr_reg`, `ptr_dig` or `skip`.
- R9: When several command strobes are high together, the winner is chosen in this order: `cmd_load`, then `cmd_copy`, then `cmd_inc`, then `cmd_dec`, then `cmd_stinc`. The losing strobes have no effect.
- R10: After an edge with no command strobe high, `ptr_reg` and `ptr_dig` hold their values and `skip` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_load | input | 1 | Load both fields from the immediate operands |
| load_reg | input | 2 | Immediate register field |
| load_dig | input | 4 | Immediate digit field |
| cmd_copy | input | 1 | Copy the accumulator into the digit field |
| acc_in | input | 4 | Accumulator value |
| cmd_inc | input | 1 | Increment the digit, flip the register field, skip on 15-to-0 |
| cmd_dec | input | 1 | Decrement the digit, flip the register field, skip on 0-to-15 |
| cmd_stinc | input | 1 | Store-immediate increment: digit + 1, no flip, no skip |
| step_r | input | 2 | XOR operand for the register field on up and down steps |
| cmd_direct | input | 1 | Force the physical address to register 3, digit 15 |
| ptr_reg | output | 2 | Current register field |
| ptr_dig | output | 4 | Current digit field |
| phys_addr | output | 5 | Physical RAM address |
| skip | output | 1 | Skip flag for the step taken at the previous edge |

## Verification
`ptr_reg`, `ptr_dig` and `skip` are registered, so a command's result is due one clock edge after the command is presented. `skip` stays high for that one cycle only. `phys_addr` is combinational from the pointer and `cmd_direct`, so it follows an override in the same cycle and follows a pointer update with no further delay.

The bench drives each command 1 ns after a rising edge. It then checks every output 1 ns after the next rising edge, against a model that applies the priority rule and modular arithmetic to the previous value. The override is checked before that edge, and the held pointer after it.

The sweeps cover:

- every pointer value with every operand for both step directions;
- every store-increment start value;
- every accumulator value for the copy;
- every combination of the five strobes for priority.

// File: rtl/ram_ptr_pkg.sv
`timescale 1ns/1ps
package ram_ptr_pkg;

    // Operation selected for the pointer in one cycle
    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_LOAD  = 3'd1,
        OP_COPY  = 3'd2,
        OP_INC   = 3'd3,
        OP_DEC   = 3'd4,
        OP_STINC = 3'd5
    } ptr_op_e;

endpackage

// File: rtl/ram_ptr_arb.sv
`timescale 1ns/1ps
// Fixed-priority pick among the command strobes
module ram_ptr_arb
    import ram_ptr_pkg::*;
(
    input  logic    cmd_load,
    input  logic    cmd_copy,
    input  logic    cmd_inc,
    input  logic    cmd_dec,
    input  logic    cmd_stinc,
    output ptr_op_e op
);

    always_comb begin
        if (cmd_load)       op = OP_LOAD;
        else if (cmd_copy)  op = OP_COPY;
        else if (cmd_inc)   op = OP_INC;
        else if (cmd_dec)   op = OP_DEC;
        else if (cmd_stinc) op = OP_STINC;
        else                op = OP_HOLD;
    end

endmodule

// File: rtl/ram_ptr_step.sv
`timescale 1ns/1ps
// Digit arithmetic and wrap detection
module ram_ptr_step #(
    parameter int DIG_W = 4
) (
    input  logic [DIG_W-1:0] dig,
    output logic [DIG_W-1:0] dig_up,
    output logic [DIG_W-1:0] dig_dn,
    output logic             wrap_up,
    output logic             wrap_dn
);

    localparam logic [DIG_W-1:0] DIG_MAX = {DIG_W{1'b1}};
    localparam logic [DIG_W-1:0] DIG_ONE = {{(DIG_W-1){1'b0}}, 1'b1};

    always_comb begin
        dig_up  = dig + DIG_ONE;
        dig_dn  = dig - DIG_ONE;
        wrap_up = (dig == DIG_MAX);
        wrap_dn = (dig == '0);
    end

endmodule

// File: rtl/ram_ptr_map.sv
`timescale 1ns/1ps
// Physical address formation with the fixed direct override
module ram_ptr_map #(
    parameter int REG_W  = 2,
    parameter int PHYS_W = 3
) (
    input  logic [REG_W-1:0]        reg_f,
    input  logic [PHYS_W-1:0]       dig_lo,
    input  logic                    direct,
    output logic [REG_W+PHYS_W-1:0] phys_addr
);

    localparam int ADDR_W = REG_W + PHYS_W;

    logic [ADDR_W-1:0] direct_addr;

    // Override target: top register, top digit (all ones)
    genvar gi;
    generate
        for (gi = 0; gi < ADDR_W; gi++) begin : g_direct
            assign direct_addr[gi] = 1'b1;
        end
    endgenerate

    always_comb begin
        if (direct) phys_addr = direct_addr;
        else        phys_addr = {reg_f, dig_lo};
    end

endmodule

// File: rtl/ram_digit_ptr.sv
`timescale 1ns/1ps
module ram_digit_ptr
    import ram_ptr_pkg::*;
#(
    parameter int REG_W  = 2,
    parameter int DIG_W  = 4,
    parameter int PHYS_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_load,
    input  logic [REG_W-1:0]        load_reg,
    input  logic [DIG_W-1:0]        load_dig,
    input  logic                    cmd_copy,
    input  logic [DIG_W-1:0]        acc_in,
    input  logic                    cmd_inc,
    input  logic                    cmd_dec,
    input  logic                    cmd_stinc,
    input  logic [REG_W-1:0]        step_r,
    input  logic                    cmd_direct,
    output logic [REG_W-1:0]        ptr_reg,
    output logic [DIG_W-1:0]        ptr_dig,
    output logic [REG_W+PHYS_W-1:0] phys_addr,
    output logic                    skip
);

    typedef struct packed {
        logic [REG_W-1:0] reg_f;
        logic [DIG_W-1:0] dig;
        logic             skip;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    ptr_op_e    op;
    logic [DIG_W-1:0] dig_up, dig_dn;
    logic             wrap_up, wrap_dn;

    ram_ptr_arb u_arb (
        .cmd_load  (cmd_load),
        .cmd_copy  (cmd_copy),
        .cmd_inc   (cmd_inc),
        .cmd_dec   (cmd_dec),
        .cmd_stinc (cmd_stinc),
        .op        (op)
    );

    ram_ptr_step #(.DIG_W(DIG_W)) u_step (
        .dig     (st_q.dig),
        .dig_up  (dig_up),
        .dig_dn  (dig_dn),
        .wrap_up (wrap_up),
        .wrap_dn (wrap_dn)
    );

    ram_ptr_map #(.REG_W(REG_W), .PHYS_W(PHYS_W)) u_map (
        .reg_f     (st_q.reg_f),
        .dig_lo    (st_q.dig[PHYS_W-1:0]),
        .direct    (cmd_direct),
        .phys_addr (phys_addr)
    );

    always_comb begin
        st_d      = st_q;
        st_d.skip = 1'b0;
        case (op)
            OP_LOAD: begin
                st_d.reg_f = load_reg;
                st_d.dig   = load_dig;
            end
            OP_COPY: begin
                st_d.dig = acc_in;
            end
            OP_INC: begin
                st_d.dig   = dig_up;
                st_d.reg_f = st_q.reg_f ^ step_r;
                st_d.skip  = wrap_up;
            end
            OP_DEC: begin
                st_d.dig   = dig_dn;
                st_d.reg_f = st_q.reg_f ^ step_r;
                st_d.skip  = wrap_dn;
            end
            OP_STINC: begin
                st_d.dig = dig_up;
            end
            default: begin
                st_d.skip = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr_reg = st_q.reg_f;
    assign ptr_dig = st_q.dig;
    assign skip    = st_q.skip;

endmodule

// File: rtl/ram_digit_ptr_chk.sv
`timescale 1ns/1ps
module ram_digit_ptr_chk #(
    parameter int REG_W  = 2,
    parameter int DIG_W  = 4,
    parameter int PHYS_W = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cmd_load,
    input logic [REG_W-1:0]        load_reg,
    input logic [DIG_W-1:0]        load_dig,
    input logic                    cmd_copy,
    input logic [DIG_W-1:0]        acc_in,
    input logic                    cmd_inc,
    input logic                    cmd_dec,
    input logic                    cmd_stinc,
    input logic                    cmd_direct,
    input logic [REG_W-1:0]        ptr_reg,
    input logic [DIG_W-1:0]        ptr_dig,
    input logic [REG_W+PHYS_W-1:0] phys_addr,
    input logic                    skip
);

    localparam logic [DIG_W-1:0] DIG_MAX = {DIG_W{1'b1}};

    // R2
    load_applies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_load |=> (ptr_reg == $past(load_reg) && ptr_dig == $past(load_dig) && !skip));

    // R3
    copy_applies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_copy && !cmd_load) |=> (ptr_dig == $past(acc_in) && $stable(ptr_reg) && !skip));

    // R4 R5
    skip_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> $past(!cmd_load && !cmd_copy &&
                       ((cmd_inc && ptr_dig == DIG_MAX) ||
                        (!cmd_inc && cmd_dec && ptr_dig == '0))));

    // R6
    store_inc_noskip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stinc && !cmd_load && !cmd_copy && !cmd_inc && !cmd_dec)
        |=> (!skip && $stable(ptr_reg) && ptr_dig == $past(ptr_dig) + 1'b1));

    // R7
    alias_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_direct |-> (phys_addr == {ptr_reg, ptr_dig[PHYS_W-1:0]}));

    // R8
    direct_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_direct |-> (phys_addr == {(REG_W+PHYS_W){1'b1}}));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_load && !cmd_copy && !cmd_inc && !cmd_dec && !cmd_stinc)
        |=> ($stable(ptr_reg) && $stable(ptr_dig) && !skip));

endmodule

bind ram_digit_ptr ram_digit_ptr_chk #(
    .REG_W(REG_W), .DIG_W(DIG_W), .PHYS_W(PHYS_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .load_reg(load_reg),
    .load_dig(load_dig), .cmd_copy(cmd_copy), .acc_in(acc_in),
    .cmd_inc(cmd_inc), .cmd_dec(cmd_dec), .cmd_stinc(cmd_stinc),
    .cmd_direct(cmd_direct), .ptr_reg(ptr_reg), .ptr_dig(ptr_dig),
    .phys_addr(phys_addr), .skip(skip)
);

// File: tb/ram_digit_ptr_bench.sv
`timescale 1ns/1ps
module ram_digit_ptr_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_load = 1'b0;
    logic [1:0] load_reg = '0;
    logic [3:0] load_dig = '0;
    logic       cmd_copy = 1'b0;
    logic [3:0] acc_in = '0;
    logic       cmd_inc = 1'b0;
    logic       cmd_dec = 1'b0;
    logic       cmd_stinc = 1'b0;
    logic [1:0] step_r = '0;
    logic       cmd_direct = 1'b0;
    logic [1:0] ptr_reg;
    logic [3:0] ptr_dig;
    logic [4:0] phys_addr;
    logic       skip;

    int n_checks = 0;
    int n_fails = 0;
    bit finished = 1'b0;

    int exp_reg = 0;
    int exp_dig = 0;
    int exp_skip = 0;

    always #2.5 clk = ~clk;

    ram_digit_ptr u_ram_digit_ptr (
        .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .load_reg(load_reg),
        .load_dig(load_dig), .cmd_copy(cmd_copy), .acc_in(acc_in),
        .cmd_inc(cmd_inc), .cmd_dec(cmd_dec), .cmd_stinc(cmd_stinc),
        .step_r(step_r), .cmd_direct(cmd_direct), .ptr_reg(ptr_reg),
        .ptr_dig(ptr_dig), .phys_addr(phys_addr), .skip(skip)
    );

    task automatic check(input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " ptr_reg"}, int'(ptr_reg), exp_reg);
        check({tag, " ptr_dig"}, int'(ptr_dig), exp_dig);
        check({tag, " skip"}, int'(skip), exp_skip);
        // R7 address aliasing: digits d and d+8 map to one cell
        check({tag, " R7 phys_addr"}, int'(phys_addr), exp_reg * 8 + (exp_dig % 8));
    endtask

    // Present strobes 1 ns after an edge, clock once, check 1 ns after the edge
    task automatic apply(input string tag, input bit ld, input int lr, input int ldg,
                         input bit cp, input int acc, input bit inc, input bit dec,
                         input bit sinc, input int r);
        cmd_load = ld; load_reg = lr[1:0]; load_dig = ldg[3:0];
        cmd_copy = cp; acc_in = acc[3:0];
        cmd_inc = inc; cmd_dec = dec; cmd_stinc = sinc; step_r = r[1:0];
        exp_skip = 0;
        if (ld) begin
            exp_reg = lr; exp_dig = ldg;
        end else if (cp) begin
            exp_dig = acc;
        end else if (inc) begin
            exp_skip = (exp_dig == 15) ? 1 : 0;
            exp_dig = (exp_dig + 1) % 16;
            exp_reg = exp_reg ^ r;
        end else if (dec) begin
            exp_skip = (exp_dig == 0) ? 1 : 0;
            exp_dig = (exp_dig + 15) % 16;
            exp_reg = exp_reg ^ r;
        end else if (sinc) begin
            exp_dig = (exp_dig + 1) % 16;
        end
        @(posedge clk); #1;
        cmd_load = 0; cmd_copy = 0; cmd_inc = 0; cmd_dec = 0; cmd_stinc = 0;
        check_all(tag);
    endtask

    task automatic load_to(input int v);
        apply("R2 load", 1'b1, v / 16, v % 16, 1'b0, 0, 1'b0, 1'b0, 1'b0, 0);
    endtask

    initial begin
        // R1 reset state
        #1;
        check_all("R1 in reset");
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        check_all("R1 after reset");

        // R2 / R7 every pointer value
        for (int v = 0; v < 64; v++) load_to(v);

        // R4 increment with every operand from every value
        for (int v = 0; v < 64; v++)
            for (int r = 0; r < 4; r++) begin
                load_to(v);
                apply("R4 inc", 1'b0, 0, 0, 1'b0, 0, 1'b1, 1'b0, 1'b0, r);
            end

        // R5 decrement with every operand from every value
        for (int v = 0; v < 64; v++)
            for (int r = 0; r < 4; r++) begin
                load_to(v);
                apply("R5 dec", 1'b0, 0, 0, 1'b0, 0, 1'b0, 1'b1, 1'b0, r);
            end

        // R6 store-increment: operand ignored, never a skip
        for (int v = 0; v < 64; v++) begin
            load_to(v);
            apply("R6 stinc", 1'b0, 0, 0, 1'b0, 0, 1'b0, 1'b0, 1'b1, 3);
        end

        // R3 accumulator copy, register field kept
        load_to(6'h25);
        for (int a = 0; a < 16; a++)
            apply("R3 copy", 1'b0, 0, 0, 1'b1, a, 1'b0, 1'b0, 1'b0, 1);

        // R9 priority across every strobe combination
        for (int m = 1; m < 32; m++) begin
            load_to(6'h0F);
            apply("R9 priority", m[0], 2, 9, m[1], 4, m[2], m[3], m[4], 1);
        end

        // R10 idle after a wrapping step
        load_to(6'h1F);
        apply("R4 wrap", 1'b0, 0, 0, 1'b0, 0, 1'b1, 1'b0, 1'b0, 0);
        apply("R10 idle", 1'b0, 0, 0, 1'b0, 0, 1'b0, 1'b0, 1'b0, 2);
        apply("R10 idle", 1'b0, 0, 0, 1'b0, 0, 1'b0, 1'b0, 1'b0, 3);

        // R8 direct override: same-cycle address, pointer untouched
        load_to(6'h12);
        cmd_direct = 1'b1;
        #1;
        check("R8 direct phys_addr", int'(phys_addr), 31);
        @(posedge clk); #1;
        check("R8 direct phys_addr held", int'(phys_addr), 31);
        check("R8 direct ptr_reg", int'(ptr_reg), exp_reg);
        check("R8 direct ptr_dig", int'(ptr_dig), exp_dig);
        check("R8 direct skip", int'(skip), 0);
        cmd_direct = 1'b0;
        #1;
        check_all("R8 released");

        // R1 reset mid-run
        load_to(6'h3B);
        rst_n = 1'b0;
        exp_reg = 0; exp_dig = 0; exp_skip = 0;
        #1;
        check_all("R1 mid-run reset");
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        check_all("R1 after mid-run reset");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule